// File: doc/BRIEF.md
# Count-Min Frequency Sketch

This block estimates how often each 64-bit sample value has been seen. It keeps several rows of small counters. Each row owns a linear hash with its own pair of coefficients, and that hash picks one bucket in the row for a given sample. An update command bumps the chosen bucket in every row. A query command reads the chosen bucket in every row and returns the smallest of those counts. Hash collisions can only inflate a counter, so the smallest count is the tightest upper bound on the true frequency.

The row count, the bucket count (a power of two), the counter width and the hash coefficients are all parameters. A query is answered two clock edges after the command. Counters from all rows are captured in the first cycle. A balanced compare tree then reduces them in the second cycle. Its depth is the base-2 logarithm of the row count. If the row count is not a power of two, the tree's spare leaves are filled with all-ones.

Top module: `cms_engine`

## Requirements
- R1: After a synchronous reset every counter reads zero and `ready_o` is low, so a query issued right after reset returns 0.
- R2: The bucket used in row r is (A_r × sample + B_r) mod 2^IDX_W, taken over 64-bit arithmetic. Two samples that agree in their low IDX_W bits therefore share a bucket in every row.
- R3: A command code of 1 (update) adds one to the addressed counter in every row.
- R4: A command code of 2 (query) returns the minimum of the addressed counters over all rows. The value is zero-extended to 64 bits on `result_o`.
- R5: `ready_o` is high for exactly one cycle for each query. It rises at the second rising clock edge after the edge that sampled the command, and `result_o` is valid in that cycle. It stays low at every other time.
- R6: Command codes 0 and 3 change no counter and produce no `ready_o` pulse.
- R7: A counter at 2^CNT_W−1 stays at that value when it is updated again. It does not wrap.
- R8: A query issued in the cycle right after an update of the same sample returns a count that includes that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command code: 0 idle, 1 update, 2 query, 3 idle |
| sample_i | input | 64 | Sample value to hash |
| result_o | output | 64 | Minimum count for the last query, zero-extended |
| ready_o | output | 1 | One-cycle pulse marking a valid `result_o` |

## Verification
Several properties are checked on every clock. Each bucket counter only ever holds, steps by exactly one, or sticks at its maximum. Counters read zero right after reset. `ready_o` follows a query command by exactly two edges. Each reported result never exceeds any of the leaves that fed it. Other behaviour needs the bench's scenarios against its own reference sketch. These cover the exact minimum under collisions, the coefficient-driven bucket choice, update-then-query forwarding, idle codes leaving the counts intact, and saturation after hundreds of updates.

// File: rtl/cms_pkg.sv
package cms_pkg;

    localparam int SAMPLE_W = 64;
    localparam int RESULT_W = 64;
    localparam int CMD_W    = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_IDLE  = 2'd0,
        CMD_BUMP  = 2'd1,
        CMD_PROBE = 2'd2,
        CMD_SPARE = 2'd3
    } cms_cmd_e;

    // Smaller of two counts; ties keep the left operand.
    function automatic logic [63:0] min2(input logic [63:0] l, input logic [63:0] r);
        return (r < l) ? r : l;
    endfunction

endpackage

// File: rtl/cms_hash.sv
module cms_hash #(
    parameter int          IDX_W  = 4,
    parameter logic [63:0] COEF_A = 64'h1,
    parameter logic [63:0] COEF_B = 64'h0
) (
    input  logic [cms_pkg::SAMPLE_W-1:0] sample_i,
    output logic [IDX_W-1:0]             idx_o
);
    // With a power-of-two modulus only the low IDX_W bits of each operand
    // can reach the low IDX_W bits of the result.
    localparam logic [IDX_W-1:0] A_LO = COEF_A[IDX_W-1:0];
    localparam logic [IDX_W-1:0] B_LO = COEF_B[IDX_W-1:0];

    logic [IDX_W-1:0] prod;

    always_comb begin
        prod  = A_LO * sample_i[IDX_W-1:0];
        idx_o = prod + B_LO;
    end

endmodule

// File: rtl/cms_row.sv
module cms_row #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             bump_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [CNT_W-1:0] count_o
);
    localparam int               DEPTH   = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] bank_q [DEPTH];

    assign count_o = bank_q[idx_i];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int k = 0; k < DEPTH; k++) bank_q[k] <= '0;
        end else if (bump_i && bank_q[idx_i] != CNT_TOP) begin
            bank_q[idx_i] <= bank_q[idx_i] + 1'b1;
        end
    end

    for (genvar b = 0; b < DEPTH; b++) begin : g_chk
        // R1: a bucket is empty on the first cycle after reset
        assert_clear_on_reset_R1: assert property (@(posedge clk_i)
            rst_i |=> bank_q[b] == '0);

        // R3: an addressed, unsaturated bucket steps by exactly one
        assert_step_one_R3: assert property (@(posedge clk_i) disable iff (rst_i)
            (bump_i && idx_i == IDX_W'(b) && bank_q[b] != CNT_TOP)
            |=> bank_q[b] == $past(bank_q[b]) + 1'b1);

        // R7: a full bucket never wraps
        assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (rst_i)
            bank_q[b] == CNT_TOP |=> bank_q[b] == CNT_TOP);

        // R6: a bucket changes only when it is addressed by an update
        assert_untouched_R6: assert property (@(posedge clk_i) disable iff (rst_i)
            !(bump_i && idx_i == IDX_W'(b)) |=> $stable(bank_q[b]));
    end

endmodule

// File: rtl/cms_min_tree.sv
module cms_min_tree #(
    parameter int LEAF_N = 4,
    parameter int CNT_W  = 8
) (
    input  logic [LEAF_N-1:0][CNT_W-1:0] leaves_i,
    output logic [CNT_W-1:0]             min_o
);
    localparam int LVLS   = (LEAF_N > 1) ? $clog2(LEAF_N) : 0;
    localparam int PAD_N  = 1 << LVLS;
    localparam int NODE_N = 2 * PAD_N - 1;

    // Heap layout: node 0 is the root, leaves start at PAD_N-1.
    logic [CNT_W-1:0] node [NODE_N];

    for (genvar i = 0; i < PAD_N; i++) begin : g_leaf
        if (i < LEAF_N) begin : g_real
            assign node[PAD_N-1+i] = leaves_i[i];
        end else begin : g_pad
            assign node[PAD_N-1+i] = '1;
        end
    end

    for (genvar j = 0; j < PAD_N - 1; j++) begin : g_cmp
        assign node[j] = CNT_W'(cms_pkg::min2(64'(node[2*j+1]), 64'(node[2*j+2])));
    end

    assign min_o = node[0];

endmodule

// File: rtl/cms_engine.sv
module cms_engine #(
    parameter int                         NUM_ROWS = 4,
    parameter int                         IDX_W    = 4,
    parameter int                         CNT_W    = 8,
    parameter logic [NUM_ROWS-1:0][63:0]  HASH_A   = {64'hD6E8FEB86659FD93, 64'h165667B19E3779F9,
                                                      64'hC2B2AE3D27D4EB4F, 64'h9E3779B97F4A7C15},
    parameter logic [NUM_ROWS-1:0][63:0]  HASH_B   = {64'h5, 64'hB, 64'h7, 64'h3}
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic [1:0]  cmd_i,
    input  logic [63:0] sample_i,
    output logic [63:0] result_o,
    output logic        ready_o
);
    import cms_pkg::*;

    cms_cmd_e                       cmd;
    logic                           bump;
    logic                           probe;
    logic [NUM_ROWS-1:0][IDX_W-1:0] idx;
    logic [NUM_ROWS-1:0][CNT_W-1:0] rd;
    logic [NUM_ROWS-1:0][CNT_W-1:0] leaf_q;
    logic                           leaf_vld_q;
    logic [CNT_W-1:0]               tree_min;

    assign cmd   = cms_cmd_e'(cmd_i);
    assign bump  = (cmd == CMD_BUMP);
    assign probe = (cmd == CMD_PROBE);

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        cms_hash #(
            .IDX_W (IDX_W),
            .COEF_A(HASH_A[r]),
            .COEF_B(HASH_B[r])
        ) u_hash (
            .sample_i(sample_i),
            .idx_o   (idx[r])
        );

        cms_row #(
            .IDX_W(IDX_W),
            .CNT_W(CNT_W)
        ) u_row (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .bump_i (bump),
            .idx_i  (idx[r]),
            .count_o(rd[r])
        );
    end

    // Stage 1: capture the addressed count of every row.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            leaf_q     <= '0;
            leaf_vld_q <= 1'b0;
        end else begin
            leaf_vld_q <= probe;
            if (probe) leaf_q <= rd;
        end
    end

    cms_min_tree #(
        .LEAF_N(NUM_ROWS),
        .CNT_W (CNT_W)
    ) u_tree (
        .leaves_i(leaf_q),
        .min_o   (tree_min)
    );

    // Stage 2: register the reduced minimum.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            result_o <= '0;
            ready_o  <= 1'b0;
        end else begin
            ready_o <= leaf_vld_q;
            if (leaf_vld_q) result_o <= RESULT_W'(tree_min);
        end
    end

    // R5: ready follows a query by exactly two edges, and nothing else raises it
    assert_ready_timing_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(rst_i, 2))
        |-> ready_o == ($past(cmd_i, 2) == 2'd2));

    // R1: ready is low right after reset
    assert_ready_reset_R1: assert property (@(posedge clk_i)
        rst_i |=> !ready_o);

    // R4: the reported minimum never exceeds any captured row count
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_min_chk
        assert_min_bound_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            leaf_vld_q |=> result_o <= RESULT_W'($past(leaf_q[r])));
    end

endmodule

// File: tb/sim_cms_engine.sv
module sim_cms_engine;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS  = 4;
    localparam int IDXW  = 4;
    localparam int CNTW  = 8;
    localparam int BUCK  = 1 << IDXW;
    localparam int CMAX  = (1 << CNTW) - 1;
    localparam logic [ROWS-1:0][63:0] TA = {64'hD6E8FEB86659FD93, 64'h165667B19E3779F9,
                                            64'hC2B2AE3D27D4EB4F, 64'h9E3779B97F4A7C15};
    localparam logic [ROWS-1:0][63:0] TB = {64'h5, 64'hB, 64'h7, 64'h3};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd = 2'd0;
    logic [63:0] sample = '0;
    logic [63:0] result;
    logic        ready;

    int tests = 0;
    int fails = 0;

    int unsigned model [ROWS][BUCK];
    logic        pv   [2];
    logic [63:0] pval [2];
    string       ptag [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    cms_engine #(
        .NUM_ROWS(ROWS), .IDX_W(IDXW), .CNT_W(CNTW), .HASH_A(TA), .HASH_B(TB)
    ) u0 (
        .clk_i(clk), .rst_i(rst), .cmd_i(cmd), .sample_i(sample),
        .result_o(result), .ready_o(ready)
    );

    function automatic int bucket(int r, logic [63:0] s);
        logic [63:0] full;
        full = TA[r] * s + TB[r];
        return int'(full % 64'(BUCK));
    endfunction

    function automatic logic [63:0] expect_min(logic [63:0] s);
        int unsigned m;
        m = 32'hFFFF_FFFF;
        for (int r = 0; r < ROWS; r++)
            if (model[r][bucket(r, s)] < m) m = model[r][bucket(r, s)];
        return 64'(m);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(logic [1:0] c, logic [63:0] s, string tag);
        @(negedge clk);
        check("R5", 64'(ready), 64'(pv[1]));
        if (pv[1]) check(ptag[1], result, pval[1]);
        pv[1] = pv[0]; pval[1] = pval[0]; ptag[1] = ptag[0];
        pv[0] = (c == 2'd2);
        pval[0] = expect_min(s);
        ptag[0] = tag;
        if (c == 2'd1)
            for (int r = 0; r < ROWS; r++)
                if (model[r][bucket(r, s)] < CMAX) model[r][bucket(r, s)]++;
        cmd = c;
        sample = s;
    endtask

    task automatic drain();
        for (int k = 0; k < 3; k++) step(2'd0, 64'h0, "R6");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < ROWS; r++)
            for (int b = 0; b < BUCK; b++) model[r][b] = 0;
        for (int k = 0; k < 2; k++) begin pv[k] = 1'b0; pval[k] = '0; ptag[k] = "R5"; end
        check("R1", 64'(ready), 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        do_reset();

        // R1: empty sketch answers zero
        step(2'd2, 64'd123, "R1");
        step(2'd2, 64'hFFFF_FFFF_FFFF_FFFF, "R1");
        drain();

        // R3 / R8: update then query in the next cycle
        step(2'd1, 64'd77, "R3");
        step(2'd2, 64'd77, "R8");
        step(2'd1, 64'd77, "R3");
        step(2'd1, 64'd77, "R3");
        step(2'd2, 64'd77, "R3");
        drain();

        // R2: equal low bits share buckets in every row; differing low bits do not need to
        step(2'd1, 64'h1234_0000_0000_0005, "R2");
        step(2'd2, 64'hABCD_0000_0000_0005, "R2");
        step(2'd2, 64'h1234_0000_0000_0006, "R2");
        step(2'd2, 64'h0000_0000_0000_0015, "R2");
        drain();

        // R6: idle and spare codes leave counters alone
        step(2'd0, 64'd77, "R6");
        step(2'd3, 64'd77, "R6");
        step(2'd3, 64'd77, "R6");
        step(2'd2, 64'd77, "R6");
        drain();

        // R7: saturation
        do_reset();
        for (int k = 0; k < 300; k++) step(2'd1, 64'd9, "R7");
        step(2'd2, 64'd9, "R7");
        drain();

        // R4: random mix with frequent collisions
        do_reset();
        for (int k = 0; k < 2000; k++) begin
            logic [1:0]  c;
            logic [63:0] s;
            c = 2'($urandom_range(0, 3));
            s = {32'($urandom), 32'($urandom_range(0, 40))};
            step(c, s, "R4");
        end
        drain();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule